// File: doc/BRIEF.md
# Lane-Mask Divergence Controller

This block manages control flow for one group of lanes that share a single instruction stream. It holds the fetch address and the active-lane mask. Each lane uses its mask bit as its write enable, so a lane whose bit is clear behaves as if it executed a no-op. On every issued step the block moves the fetch address forward. At a conditional branch it compares the per-lane condition bits with the mask. If all live lanes agree, the block jumps straight to the chosen path and spends no extra pass. If they disagree, it runs the else path first with only the false lanes enabled, then the taken path with only the true lanes enabled, and then rejoins.

A four-entry reconvergence stack supports nested divergence. Each entry records four things: where the paths meet again, where the taken path starts, which lanes take it, and the mask that was live before the branch. Simple two-way choices do not need a branch. They are resolved per lane through a predicated select output, which never touches the mask or the stack.

Top module: `simt_div_top`

## Requirements
- R1: After reset the active mask is all ones, the fetch address is 0, the stack depth is 0 and the overflow flag is clear.
- R2: A step with `isBranch` low advances the fetch address by one on the next clock edge and leaves the mask unchanged. A cycle with `stepValid` low changes nothing.
- R3: A branch on which every active lane's condition is 1 loads `takenPc`. A branch on which every active lane's condition is 0 loads `elsePc`. In both cases the mask and the stack depth are unchanged.
- R4: Condition bits of inactive lanes play no part in the uniformity test. They are forced to 0 in both split masks.
- R5: A divergent branch loads `elsePc`, sets the mask to (active AND NOT condition) and adds one to the stack depth.
- R6: When the next fetch address equals the top entry's join address during its else pass, the fetch address becomes that entry's taken target. The mask becomes (pre-branch mask AND condition), and the depth is unchanged.
- R7: When the next fetch address equals the top entry's join address during its taken pass, the entry is popped. The mask returns to the pre-branch value and the fetch address is the join address.
- R8: Divergent branches nest up to 4 levels deep, one stack entry per level.
- R9: A divergent branch while 4 entries are held sets the sticky overflow flag. The mask and the depth stay unchanged and the fetch address advances by one. The flag then stays set until reset.
- R10: For every lane i, `selOut` lane i equals `selA` lane i when `laneCond[i]` is 1, and `selB` lane i otherwise. Lane i occupies bits [i*W+W-1 : i*W].
- R11: `laneWrEn` equals `activeMask` when `stepValid` is high and is all zeros otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stepValid | input | 1 | An instruction issues at `fetchPc` this cycle |
| isBranch | input | 1 | The issued instruction is a conditional branch |
| laneCond | input | LANES | Per-lane condition bit (branch or select) |
| takenPc | input | PCW | Start of the taken path |
| elsePc | input | PCW | Start of the else path |
| joinPc | input | PCW | Address where both paths meet again |
| selA | input | LANES*W | Per-lane value chosen when the condition is 1 |
| selB | input | LANES*W | Per-lane value chosen when the condition is 0 |
| activeMask | output | LANES | Current active-lane mask |
| laneWrEn | output | LANES | Per-lane write enable for the issued step |
| fetchPc | output | PCW | Address of the next instruction to fetch |
| stackDepth | output | SPW | Number of reconvergence entries held |
| overflow | output | 1 | Sticky flag: a push was refused because the stack was full |
| selOut | output | LANES*W | Per-lane predicated select result |

## Verification
A corrupted stack entry stays hidden until its join address is reached. It then shows as a wrong fetch address or a wrong mask at the flip or at the pop, which can be many steps after the fault. The scenarios therefore drive every pass through to its join, at one level and at two levels, so that each stored field reaches the ports. A bad split mask or a missed uniformity test shows on `activeMask`, `fetchPc` or `stackDepth` in the cycle right after the branch edge.

// File: rtl/simt_div_pkg.sv
package simt_div_pkg;

  typedef enum logic [1:0] {
    PC_SEQ    = 2'd0,
    PC_ELSE   = 2'd1,
    PC_TAKEN  = 2'd2,
    PC_RESUME = 2'd3
  } pcSel_e;

  typedef enum logic [1:0] {
    MK_KEEP    = 2'd0,
    MK_FALSE   = 2'd1,
    MK_RESUME  = 2'd2,
    MK_RESTORE = 2'd3
  } maskSel_e;

  typedef struct packed {
    logic     load;
    logic     push;
    logic     pop;
    logic     flip;
    logic     setOvf;
    pcSel_e   pcSel;
    maskSel_e maskSel;
  } ctrlStrb_t;

endpackage

// File: rtl/simt_div_ctrl.sv
module simt_div_ctrl
  import simt_div_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      stepValid,
  input  logic      isBranch,
  input  logic      anyActive,
  input  logic      anyTrue,
  input  logic      anyFalse,
  input  logic      stackFull,
  input  logic      topInElse,
  input  logic      seqHit,
  input  logic      elseHit,
  input  logic      takenHit,
  output ctrlStrb_t strb
);

  logic   diverge;
  logic   hit;
  pcSel_e cand;

  always_comb begin
    strb         = '0;
    strb.pcSel   = PC_SEQ;
    strb.maskSel = MK_KEEP;
    strb.load    = stepValid;
    diverge      = 1'b0;
    cand         = PC_SEQ;
    hit          = seqHit;
    if (stepValid) begin
      if (isBranch && anyActive) begin
        if (!anyTrue) begin
          cand = PC_ELSE;
          hit  = elseHit;
        end else if (!anyFalse) begin
          cand = PC_TAKEN;
          hit  = takenHit;
        end else if (stackFull) begin
          strb.setOvf = 1'b1;
        end else begin
          diverge      = 1'b1;
          strb.push    = 1'b1;
          strb.pcSel   = PC_ELSE;
          strb.maskSel = MK_FALSE;
        end
      end
      if (!diverge) begin
        strb.pcSel = cand;
        if (hit) begin
          if (topInElse) begin
            strb.flip    = 1'b1;
            strb.pcSel   = PC_RESUME;
            strb.maskSel = MK_RESUME;
          end else begin
            strb.pop     = 1'b1;
            strb.maskSel = MK_RESTORE;
          end
        end
      end
    end
  end

  // R8: at most one stack operation per step
  assert_one_stack_op_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.push, strb.pop, strb.flip}));

  // R9: a push is never issued into a full stack
  assert_no_push_when_full_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> !stackFull);

endmodule

// File: rtl/simt_div_path.sv
module simt_div_path
  import simt_div_pkg::*;
#(
  parameter int LANES = 8,
  parameter int PCW   = 16,
  parameter int DEPTH = 4,
  localparam int SPW  = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic [LANES-1:0] laneCond,
  input  logic [PCW-1:0]   takenPc,
  input  logic [PCW-1:0]   elsePc,
  input  logic [PCW-1:0]   joinPc,
  output logic             anyActive,
  output logic             anyTrue,
  output logic             anyFalse,
  output logic             stackFull,
  output logic             topInElse,
  output logic             seqHit,
  output logic             elseHit,
  output logic             takenHit,
  output logic [LANES-1:0] mask,
  output logic [PCW-1:0]   pc,
  output logic [SPW-1:0]   sp,
  output logic             ovf
);

  typedef struct packed {
    logic [PCW-1:0]   joinAddr;
    logic [PCW-1:0]   takenAddr;
    logic [LANES-1:0] trueMask;
    logic [LANES-1:0] prevMask;
    logic             inElse;
  } stkEntry_t;

  stkEntry_t        stk [DEPTH];
  stkEntry_t        top;
  logic [LANES-1:0] tMask, fMask;
  logic [PCW-1:0]   seqPc, pcNext;
  logic [LANES-1:0] maskNext;
  logic [SPW-1:0]   spM1;
  logic [IW-1:0]    wrIdx, topIdx;
  logic             stackEmpty;

  assign tMask      = laneCond & mask;
  assign fMask      = ~laneCond & mask;
  assign anyActive  = |mask;
  assign anyTrue    = |tMask;
  assign anyFalse   = |fMask;
  assign seqPc      = pc + PCW'(1);
  assign spM1       = sp - SPW'(1);
  assign wrIdx      = sp[IW-1:0];
  assign topIdx     = spM1[IW-1:0];
  assign top        = stk[topIdx];
  assign stackEmpty = (sp == '0);
  assign stackFull  = (sp == SPW'(DEPTH));
  assign topInElse  = top.inElse;
  assign seqHit     = !stackEmpty && (seqPc == top.joinAddr);
  assign elseHit    = !stackEmpty && (elsePc == top.joinAddr);
  assign takenHit   = !stackEmpty && (takenPc == top.joinAddr);

  always_comb begin
    unique case (strb.pcSel)
      PC_ELSE:   pcNext = elsePc;
      PC_TAKEN:  pcNext = takenPc;
      PC_RESUME: pcNext = top.takenAddr;
      default:   pcNext = seqPc;
    endcase
    unique case (strb.maskSel)
      MK_FALSE:   maskNext = fMask;
      MK_RESUME:  maskNext = top.trueMask;
      MK_RESTORE: maskNext = top.prevMask;
      default:    maskNext = mask;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc   <= '0;
      mask <= '1;
      sp   <= '0;
      ovf  <= 1'b0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
    end else if (strb.load) begin
      pc   <= pcNext;
      mask <= maskNext;
      if (strb.setOvf) ovf <= 1'b1;
      if (strb.push) begin
        stk[wrIdx] <= '{joinAddr: joinPc, takenAddr: takenPc,
                        trueMask: tMask, prevMask: mask, inElse: 1'b1};
        sp <= sp + SPW'(1);
      end else if (strb.pop) begin
        sp <= spM1;
      end else if (strb.flip) begin
        stk[topIdx].inElse <= 1'b0;
      end
    end
  end

  // R5: a divergent split only ever removes lanes
  assert_split_subset_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |=> ((mask & ~$past(mask)) == '0));

  // R9: overflow flag is sticky
  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    ovf |=> ovf);

  // R9: a refused push raises the flag on the next cycle
  assert_ovf_raise_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.setOvf |=> ovf);

  // R8: depth never exceeds the stack size
  assert_depth_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    sp <= SPW'(DEPTH));

  // R2: without a stack operation or split the mask holds
  assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.push || strb.pop || strb.flip) |=> $stable(mask));

endmodule

// File: rtl/simt_lane_sel.sv
module simt_lane_sel #(
  parameter int LANES = 8,
  parameter int W     = 8
) (
  input  logic [LANES-1:0]   laneCond,
  input  logic [LANES*W-1:0] selA,
  input  logic [LANES*W-1:0] selB,
  output logic [LANES*W-1:0] selOut
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign selOut[i*W +: W] = laneCond[i] ? selA[i*W +: W] : selB[i*W +: W];
  end

endmodule

// File: rtl/simt_div_top.sv
module simt_div_top
  import simt_div_pkg::*;
#(
  parameter int LANES = 8,
  parameter int W     = 8,
  parameter int PCW   = 16,
  parameter int DEPTH = 4,
  localparam int SPW  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               stepValid,
  input  logic               isBranch,
  input  logic [LANES-1:0]   laneCond,
  input  logic [PCW-1:0]     takenPc,
  input  logic [PCW-1:0]     elsePc,
  input  logic [PCW-1:0]     joinPc,
  input  logic [LANES*W-1:0] selA,
  input  logic [LANES*W-1:0] selB,
  output logic [LANES-1:0]   activeMask,
  output logic [LANES-1:0]   laneWrEn,
  output logic [PCW-1:0]     fetchPc,
  output logic [SPW-1:0]     stackDepth,
  output logic               overflow,
  output logic [LANES*W-1:0] selOut
);

  ctrlStrb_t strb;
  logic anyActive, anyTrue, anyFalse, stackFull, topInElse;
  logic seqHit, elseHit, takenHit;

  simt_div_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .stepValid(stepValid), .isBranch(isBranch),
    .anyActive(anyActive), .anyTrue(anyTrue), .anyFalse(anyFalse),
    .stackFull(stackFull), .topInElse(topInElse), .seqHit(seqHit),
    .elseHit(elseHit), .takenHit(takenHit), .strb(strb)
  );

  simt_div_path #(.LANES(LANES), .PCW(PCW), .DEPTH(DEPTH)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .laneCond(laneCond),
    .takenPc(takenPc), .elsePc(elsePc), .joinPc(joinPc),
    .anyActive(anyActive), .anyTrue(anyTrue), .anyFalse(anyFalse),
    .stackFull(stackFull), .topInElse(topInElse), .seqHit(seqHit),
    .elseHit(elseHit), .takenHit(takenHit), .mask(activeMask),
    .pc(fetchPc), .sp(stackDepth), .ovf(overflow)
  );

  simt_lane_sel #(.LANES(LANES), .W(W)) u_sel (
    .laneCond(laneCond), .selA(selA), .selB(selB), .selOut(selOut)
  );

  assign laneWrEn = stepValid ? activeMask : '0;

endmodule

// File: tb/simt_div_top_bench.sv
module simt_div_top_bench;
  localparam int LANES = 8, W = 8, PCW = 16, DEPTH = 4;
  localparam int SPW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rstN = 1'b0;
  logic stepValid = 1'b0, isBranch = 1'b0;
  logic [LANES-1:0] laneCond = '0;
  logic [PCW-1:0] takenPc = '0, elsePc = '0, joinPc = '0;
  logic [LANES*W-1:0] selA = '0, selB = '0;
  logic [LANES-1:0] activeMask, laneWrEn;
  logic [PCW-1:0] fetchPc;
  logic [SPW-1:0] stackDepth;
  logic overflow;
  logic [LANES*W-1:0] selOut;

  simt_div_top u_simt_div_top (.*);

  always #2 clk = ~clk;

  typedef struct {
    int    pc;
    int    mask;
    int    depth;
    int    ovf;
    string tag;
  } expItem_t;

  expItem_t q[$];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: apply one step, queue the expected post-edge state
  task automatic step(input bit v, input bit br, input int cond, input int tk,
                      input int el, input int jn, input int ePc, input int eMask,
                      input int eDepth, input int eOvf, input string tag);
    expItem_t it;
    @(negedge clk);
    stepValid = v; isBranch = br; laneCond = LANES'(cond);
    takenPc = PCW'(tk); elsePc = PCW'(el); joinPc = PCW'(jn);
    it = '{pc: ePc, mask: eMask, depth: eDepth, ovf: eOvf, tag: tag};
    q.push_back(it);
  endtask

  // monitor: compare after each edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      expItem_t e;
      e = q.pop_front();
      check(int'(fetchPc) == e.pc, {e.tag, " pc"}, int'(fetchPc), e.pc);
      check(int'(activeMask) == e.mask, {e.tag, " mask"}, int'(activeMask), e.mask);
      check(int'(stackDepth) == e.depth, {e.tag, " depth"}, int'(stackDepth), e.depth);
      check(int'(overflow) == e.ovf, {e.tag, " ovf"}, int'(overflow), e.ovf);
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(fetchPc == '0 && activeMask == 8'hFF && stackDepth == '0 && !overflow,
          "R1 reset state", int'(activeMask), 8'hFF);
    rstN = 1'b1;

    // R11: idle cycle gives no write enables
    #1;
    check(laneWrEn == '0, "R11 idle wrEn", int'(laneWrEn), 0);

    step(1, 0, 'h00, 0, 0, 0, 1, 'hFF, 0, 0, "R2 plain step");
    #1;
    check(laneWrEn == 8'hFF, "R11 active wrEn", int'(laneWrEn), 'hFF);
    step(0, 0, 'h00, 0, 0, 0, 1, 'hFF, 0, 0, "R2 idle hold");

    // R10: predicated select on a plain step, mask must not move
    step(1, 0, 'h5A, 0, 0, 0, 2, 'hFF, 0, 0, "R10 select keeps mask");
    selA = '0; selB = '0;
    for (int i = 0; i < LANES; i++) begin
      selA[i*W +: W] = W'(8'h10 + i);
      selB[i*W +: W] = W'(8'hA0 + i);
    end
    #1;
    for (int i = 0; i < LANES; i++) begin
      int expv;
      expv = ((8'h5A >> i) & 1) != 0 ? (8'h10 + i) : (8'hA0 + i);
      check(int'(selOut[i*W +: W]) == expv, "R10 lane select",
            int'(selOut[i*W +: W]), expv);
    end

    // R3 uniform branches
    step(1, 1, 'hFF, 10, 20, 30, 10, 'hFF, 0, 0, "R3 uniform taken");
    step(1, 1, 'h00, 40, 50, 60, 50, 'hFF, 0, 0, "R3 uniform else");

    // R5 divergent, else pass first
    step(1, 1, 'h0F, 100, 200, 300, 200, 'hF0, 1, 0, "R5 divergent split");
    // R4: inactive lanes true, active lanes all false -> uniform else
    step(1, 1, 'h0F, 110, 210, 400, 210, 'hF0, 1, 0, "R4 inactive cond ignored");
    step(1, 1, 'hF0, 299, 0, 0, 299, 'hF0, 1, 0, "R3 uniform on partial mask");
    step(1, 0, 'h00, 0, 0, 0, 100, 'h0F, 1, 0, "R6 flip to taken pass");

    // R8 nested divergence inside the taken pass
    step(1, 1, 'h03, 120, 130, 140, 130, 'h0C, 2, 0, "R8 nested push");
    step(1, 1, 'h0C, 139, 0, 0, 139, 'h0C, 2, 0, "R3 inner uniform");
    step(1, 0, 'h00, 0, 0, 0, 120, 'h03, 2, 0, "R6 inner flip");
    step(1, 1, 'h03, 139, 0, 0, 139, 'h03, 2, 0, "R3 inner taken body");
    step(1, 0, 'h00, 0, 0, 0, 140, 'h0F, 1, 0, "R7 inner pop");
    step(1, 1, 'h0F, 299, 0, 0, 299, 'h0F, 1, 0, "R3 outer taken body");
    step(1, 0, 'h00, 0, 0, 0, 300, 'hFF, 0, 0, "R7 outer pop");

    // R8/R9 fill the stack, then overflow
    step(1, 1, 'h01, 1000, 500, 600, 500, 'hFE, 1, 0, "R8 level 1");
    step(1, 1, 'h03, 1001, 510, 610, 510, 'hFC, 2, 0, "R4 level 2 forced");
    step(1, 1, 'h04, 1002, 520, 620, 520, 'hF8, 3, 0, "R8 level 3");
    step(1, 1, 'h08, 1003, 530, 630, 530, 'hF0, 4, 0, "R8 level 4");
    step(1, 1, 'h10, 1004, 540, 640, 531, 'hF0, 4, 1, "R9 overflow refused");
    step(1, 0, 'h00, 0, 0, 0, 532, 'hF0, 4, 1, "R9 flag sticky");
    step(0, 0, 'h00, 0, 0, 0, 532, 'hF0, 4, 1, "R9 idle after overflow");

    @(negedge clk); stepValid = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule